// File: doc/BRIEF.md
# Multiple-Reset Checkpoint Sequencer

This block sets the frame timing for an imager that widens its dynamic range by resetting pixels conditionally. A frame starts with an unconditional reset of every pixel. The total integration time T is a power of two in clock cycles and is chosen per frame. The block then places NBITS saturation checkpoints at the moments where the remaining integration time has shrunk to T/2, T/4, …, T/2^NBITS. At each checkpoint it scans the rows one per cycle towards the column comparators. A flag marks the first checkpoint of the frame.

In global-shutter mode, every pixel starts to integrate at the same moment. The scan of all rows at a checkpoint is followed by one array-wide conditional reset strobe.

In rolling-shutter mode, each row is offset from the previous row by one cycle. Only one row is touched in any cycle, and every compare carries its own per-row conditional reset enable.

When integration ends, the block emits a frame-end pulse and reads the rows out in order. A timing set-up in which a checkpoint scan cannot finish inside its own sub-interval is refused with an error flag.

Top module: `wdr_ckpt_seq`

## Requirements
- R1: After reset, busy_o, err_o and all strobes are 0 and row_o is 0.
- R2: On an accepted start, cycle 0 is the cycle after the start edge. In global mode, frst_o is high for cycle 0 only, with row_o=0. In rolling mode, frst_o is high in cycles 0..ROWS-1 with row_o equal to the cycle number.
- R3: Checkpoint k (k = 1..NBITS) begins at cycle c_k = T - (T >> k), where T = 2^tlog_i.
- R4: During checkpoint k, cmp_o is high in cycles c_k+r with row_o=r, for r = 0..ROWS-1. At most one of frst_o, cmp_o, grst_o and rd_o is high in any cycle.
- R5: first_o is high exactly in the compare cycles of checkpoint 1.
- R6: In global mode, grst_o is high for one cycle at c_k+ROWS after every checkpoint, and rrst_o stays 0.
- R7: In rolling mode, rrst_o is high together with every cmp_o, and grst_o stays 0.
- R8: fend_o pulses at cycle T. rd_o is high in cycles T+r with row_o=r. busy_o is high from cycle 0 to cycle T+ROWS-1 and low afterwards.
- R9: A start with tlog_i > TLOG_MAX, or with (2^tlog_i >> NBITS) < ROWS+1, sets err_o and starts no frame. The next accepted start clears err_o.
- R10: start_i and gmode_i are ignored while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a new frame |
| gmode_i | input | 1 | 1 selects global shutter, 0 selects rolling; sampled at start |
| tlog_i | input | TLW | log2 of the integration time in cycles; sampled at start |
| busy_o | output | 1 | Frame in progress |
| err_o | output | 1 | Last start was refused because its timing is infeasible |
| row_o | output | RW | Row address for reset, compare or readout |
| frst_o | output | 1 | Unconditional frame-start reset |
| cmp_o | output | 1 | Non-destructive read and compare of row row_o |
| first_o | output | 1 | Current compare belongs to the first checkpoint |
| rrst_o | output | 1 | Per-row conditional reset enable (rolling mode) |
| grst_o | output | 1 | Array-wide conditional reset (global mode) |
| rd_o | output | 1 | Final readout of row row_o is valid |
| fend_o | output | 1 | Integration of the frame has ended |

## Verification
A wrong checkpoint index or a wrong cycle count shows up in the first cycle that differs from the expected schedule. The symptom is a compare at the wrong cycle, a wrong row address, a misplaced first-check flag, or a global reset in the wrong place. Every output is compared in every cycle of whole frames, in both modes and for several integration lengths. So a fault in the counter or in the mode latch is reported within one cycle of the event it displaces. Refused starts are checked by watching that busy_o stays low and that no strobe follows. Starts issued in the middle of a frame are checked by confirming that the schedule of the running frame does not change.

// File: rtl/wdr_ckpt_seq.sv
module wdr_ckpt_seq #(
  parameter int ROWS     = 8,
  parameter int NBITS    = 4,
  parameter int TLOG_MAX = 12,
  localparam int RW  = $clog2(ROWS),
  localparam int TLW = $clog2(TLOG_MAX + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           gmode_i,
  input  logic [TLW-1:0] tlog_i,
  output logic           busy_o,
  output logic           err_o,
  output logic [RW-1:0]  row_o,
  output logic           frst_o,
  output logic           cmp_o,
  output logic           first_o,
  output logic           rrst_o,
  output logic           grst_o,
  output logic           rd_o,
  output logic           fend_o
);
  localparam int CW = TLOG_MAX + 2;
  localparam int KW = $clog2(NBITS + 2);

  logic           busy_q, glob_q, err_q;
  logic [TLW-1:0] tlog_q;
  logic [CW-1:0]  cnt_q;
  logic [KW-1:0]  k_q;

  wire [CW-1:0] tlen    = CW'(1) << tlog_q;
  wire [CW-1:0] cp      = tlen - (tlen >> k_q);
  wire          ck_live = busy_q && (k_q <= KW'(NBITS));
  wire          in_scan = ck_live && (cnt_q >= cp) && (cnt_q < cp + CW'(ROWS));
  wire          at_gap  = ck_live && (cnt_q == cp + CW'(ROWS));
  wire          in_rst  = busy_q && (glob_q ? (cnt_q == '0) : (cnt_q < CW'(ROWS)));
  wire          in_read = busy_q && (cnt_q >= tlen) && (cnt_q < tlen + CW'(ROWS));
  wire          last    = busy_q && (cnt_q == tlen + CW'(ROWS - 1));

  wire [CW-1:0] tnew = CW'(1) << tlog_i;
  wire          bad  = (tlog_i > TLW'(TLOG_MAX)) || ((tnew >> NBITS) < CW'(ROWS + 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      glob_q <= 1'b0;
      err_q  <= 1'b0;
      tlog_q <= '0;
      cnt_q  <= '0;
      k_q    <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        err_q <= bad;
        if (!bad) begin
          busy_q <= 1'b1;
          glob_q <= gmode_i;
          tlog_q <= tlog_i;
          cnt_q  <= '0;
          k_q    <= KW'(1);
        end
      end
    end else begin
      cnt_q <= cnt_q + CW'(1);
      if (at_gap) k_q <= k_q + KW'(1);
      if (last)   busy_q <= 1'b0;
    end
  end

  assign busy_o  = busy_q;
  assign err_o   = err_q;
  assign frst_o  = in_rst;
  assign cmp_o   = in_scan;
  assign first_o = in_scan && (k_q == KW'(1));
  assign rrst_o  = in_scan && !glob_q;
  assign grst_o  = at_gap && glob_q;
  assign rd_o    = in_read;
  assign fend_o  = busy_q && (cnt_q == tlen);
  assign row_o   = in_scan ? RW'(cnt_q - cp)   :
                   in_read ? RW'(cnt_q - tlen) :
                   in_rst  ? RW'(cnt_q)        : '0;
endmodule

// File: rtl/wdr_ckpt_seq_chk.sv
module wdr_ckpt_seq_chk #(
  parameter int ROWS = 8,
  localparam int RW = $clog2(ROWS)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          err_o,
  input logic [RW-1:0] row_o,
  input logic          frst_o,
  input logic          cmp_o,
  input logic          first_o,
  input logic          rrst_o,
  input logic          grst_o,
  input logic          rd_o,
  input logic          fend_o,
  input logic          glob_q
);
  a_r4_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({frst_o, cmp_o, grst_o, rd_o}));
  a_r5_first_in_scan: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_o |-> cmp_o);
  a_r6_grst_after_scan: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grst_o |-> ($past(cmp_o) && $past(row_o) == RW'(ROWS - 1)));
  a_r7_rrst_rolling: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rrst_o |-> (cmp_o && !glob_q));
  a_r8_fend_first_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fend_o |-> (rd_o && row_o == '0));
  a_r9_err_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !busy_o);
  a_r10_mode_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(glob_q));
endmodule

bind wdr_ckpt_seq wdr_ckpt_seq_chk #(.ROWS(ROWS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .err_o(err_o), .row_o(row_o),
  .frst_o(frst_o), .cmp_o(cmp_o), .first_o(first_o), .rrst_o(rrst_o),
  .grst_o(grst_o), .rd_o(rd_o), .fend_o(fend_o), .glob_q(glob_q)
);

// File: tb/wdr_ckpt_seq_test.sv
`timescale 1ns/1ps
module wdr_ckpt_seq_test;
  localparam int ROWS = 8, NBITS = 4, TLOG_MAX = 12;
  localparam int RW = $clog2(ROWS), TLW = $clog2(TLOG_MAX + 1);

  logic clk = 0, rst_n = 0, start = 0, gmode = 0;
  logic [TLW-1:0] tlog = '0;
  logic busy, err, frst, cmp, first, rrst, grst, rd, fend;
  logic [RW-1:0] row;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  wdr_ckpt_seq #(.ROWS(ROWS), .NBITS(NBITS), .TLOG_MAX(TLOG_MAX)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .gmode_i(gmode), .tlog_i(tlog),
    .busy_o(busy), .err_o(err), .row_o(row), .frst_o(frst), .cmp_o(cmp),
    .first_o(first), .rrst_o(rrst), .grst_o(grst), .rd_o(rd), .fend_o(fend));

  task automatic chk(string tag, int act, int exp, int c);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d: actual=%0d expected=%0d", tag, c, act, exp);
    end
  endtask

  task automatic model(input int c, input bit g, input int tl,
                       output bit e_frst, output bit e_cmp, output bit e_first,
                       output bit e_rrst, output bit e_grst, output bit e_rd,
                       output bit e_fend, output bit e_busy, output int e_row);
    int t;
    t = 1 << tl;
    e_cmp = 0; e_first = 0; e_rrst = 0; e_grst = 0; e_row = 0;
    e_busy = (c < t + ROWS);
    e_frst = g ? (c == 0) : (c < ROWS);
    if (e_frst) e_row = c;
    for (int k = 1; k <= NBITS; k++) begin
      int cpk;
      cpk = t - (t >> k);
      if (c >= cpk && c < cpk + ROWS) begin
        e_cmp = 1; e_first = (k == 1); e_rrst = !g; e_row = c - cpk;
      end
      if (g && c == cpk + ROWS) e_grst = 1;
    end
    e_rd = (c >= t && c < t + ROWS);
    if (e_rd) e_row = c - t;
    e_fend = (c == t);
  endtask

  task automatic run_frame(bit g, int tl, bit poke);
    string p;
    p = poke ? "R10/" : "";
    @(negedge clk); start = 1; gmode = g; tlog = TLW'(tl);
    @(negedge clk); start = 0;
    for (int c = 0; c <= (1 << tl) + ROWS; c++) begin
      bit ef, ec, e1, er, eg, ed, en, eb;
      int ew;
      model(c, g, tl, ef, ec, e1, er, eg, ed, en, eb, ew);
      chk({p, "R2 frst"}, frst, ef, c);
      chk({p, "R3/R4 cmp"}, cmp, ec, c);
      chk({p, "R4 row"}, row, ew, c);
      chk({p, "R5 first"}, first, e1, c);
      chk({p, "R6 grst"}, grst, eg, c);
      chk({p, "R7 rrst"}, rrst, er, c);
      chk({p, "R8 rd"}, rd, ed, c);
      chk({p, "R8 fend"}, fend, en, c);
      chk({p, "R8 busy"}, busy, eb, c);
      chk({p, "R9 err clear"}, err, 0, c);
      if (poke && (c == 5 || c == (1 << tl) - 2)) begin
        start = 1; gmode = !g; tlog = TLW'(tl + 1);
      end
      @(negedge clk); start = 0;
    end
  endtask

  task automatic bad_start(int tl);
    @(negedge clk); start = 1; gmode = 1; tlog = TLW'(tl);
    @(negedge clk); start = 0;
    for (int c = 0; c < 6; c++) begin
      chk("R9 err", err, 1, c);
      chk("R9 busy", busy, 0, c);
      chk("R9 strobes", {frst, cmp, grst, rd, fend}, 0, c);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0, 0);
    chk("R1 err", err, 0, 0);
    chk("R1 strobes", {frst, cmp, first, rrst, grst, rd, fend}, 0, 0);
    chk("R1 row", row, 0, 0);
    rst_n = 1;
    run_frame(1, 8, 0);
    run_frame(0, 8, 0);
    bad_start(7);
    run_frame(1, 9, 1);
    bad_start(13);
    run_frame(0, 9, 1);
    bad_start(15);
    for (int i = 0; i < 5; i++) begin
      bit g;
      int tl;
      g  = 1'($urandom_range(1, 0));
      tl = $urandom_range(10, 8);
      run_frame(g, tl, 1'($urandom_range(1, 0)));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule